// File: doc/BRIEF.md
# Subclass-Masked I/O Interrupt Selector

This block keeps pending I/O interrupt entries in one last-in-first-out stack for each of eight interruption subclasses. An entry carries a subchannel id, a subchannel number, a parameter word and an interrupt word. The entry's subclass is a 3-bit field inside its interrupt word, and the push port routes the entry to the stack for that subclass.

When the core raises a deliver strobe, the block scans the subclasses from the lowest number upward. It pops one entry from the first non-empty stack whose subclass is enabled in an 8-bit mask. The popped entry appears on registered outputs in the next cycle. A summary bit reports whether any stack, enabled or not, still holds an entry. A deliver request made while the global I/O enable input is low is a fault, as is a push to a full stack. Both faults raise an error pulse. Writing the entry into the saved-state area in memory is left to the consumer.

Top module: `io_irq_sel`

## Requirements
- R1: Each subclass stack delivers its most recently pushed entry first.
- R2: A delivery picks the lowest-numbered subclass whose stack is non-empty and whose mask bit (bit n of `sc_mask_i` for subclass n) is 1.
- R3: Each delivery request pops at most one entry, even when several subclasses are eligible.
- R4: A non-empty stack whose subclass is masked is skipped by delivery, and its entries keep `pending_o` high.
- R5: `pending_o` is low exactly when every stack is empty, whatever the mask.
- R6: A delivery request while `io_en_i` is 0 pops nothing, leaves `out_valid_o` low and raises `err_o` for one cycle.
- R7: A push to a stack that already holds DEPTH entries (default 4) is discarded, leaves that stack's contents unchanged and raises `err_o` for one cycle.
- R8: An entry's subclass is taken from interrupt word bits [26:24]. A delivered entry presents its 16-bit id, 16-bit number, 32-bit parameter and 32-bit interrupt word unchanged.
- R9: While reset is asserted and after it is released, all stacks are empty and `out_valid_o`, `err_o` and `pending_o` are 0.
- R10: When a push and a delivery that pops the same stack occur in one cycle, the delivery returns the entry that was on top before that cycle and the pushed entry stays stored.
- R11: `out_valid_o` and the entry outputs update in the cycle after the request. `out_valid_o` is 0 when the request finds no eligible entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push the entry on the push fields |
| push_id_i | input | 16 | Subchannel id of pushed entry |
| push_nr_i | input | 16 | Subchannel number of pushed entry |
| push_parm_i | input | 32 | Interrupt parameter of pushed entry |
| push_word_i | input | 32 | Interrupt word; bits [26:24] give the subclass |
| deliver_i | input | 1 | Request delivery of one entry |
| sc_mask_i | input | 8 | Subclass enable mask, bit n enables subclass n |
| io_en_i | input | 1 | Global I/O interrupt enable |
| out_id_o | output | 16 | Delivered subchannel id |
| out_nr_o | output | 16 | Delivered subchannel number |
| out_parm_o | output | 32 | Delivered parameter |
| out_word_o | output | 32 | Delivered interrupt word |
| out_valid_o | output | 1 | Delivered entry valid, one cycle |
| err_o | output | 1 | Fault pulse: delivery while disabled or push to full stack |
| pending_o | output | 1 | Some stack still holds an entry |

## Verification
A stack pointer that is off by one would show on the entry outputs in the cycle after the next delivery, as a stale or wrong id. A lost or doubled pop would show on `pending_o` when the last entry drains. A wrong scan order or a mask test with the wrong sense would show as the wrong subclass being delivered on the first request where two subclasses compete. A faulty full check would surface only on a later run of pops, as a missing or overwritten entry. The bench therefore drains every stack it fills.

// File: rtl/io_irq_pkg.sv
package io_irq_pkg;
  typedef struct packed {
    logic [15:0] id;
    logic [15:0] nr;
    logic [31:0] parm;
    logic [31:0] word;
  } irq_ent_t;

  localparam int unsigned ENT_W = $bits(irq_ent_t);
endpackage

// File: rtl/io_irq_lifo.sv
module io_irq_lifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] top;
  logic          do_push;

  assign top     = cnt - CW'(1);
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign dout_o  = mem[top[AW-1:0]];
  assign do_push = push_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
    end else if (do_push && !pop_i) begin
      cnt <= cnt + CW'(1);
    end else if (pop_i && !do_push) begin
      cnt <= top;
    end
  end

  // replace-on-top when push and pop meet; push above top otherwise
  always_ff @(posedge clk_i) begin
    if (do_push && pop_i)  mem[top[AW-1:0]] <= din_i;
    else if (do_push)      mem[cnt[AW-1:0]] <= din_i;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R7
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/io_irq_pick.sv
module io_irq_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] sel_o,
  output logic         hit_o
);
  always_comb begin
    sel_o = '0;
    hit_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!hit_o && req_i[i] && en_i[i]) begin
        sel_o[i] = 1'b1;
        hit_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/io_irq_sel.sv
module io_irq_sel
  import io_irq_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned SC_POS = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [15:0] push_id_i,
  input  logic [15:0] push_nr_i,
  input  logic [31:0] push_parm_i,
  input  logic [31:0] push_word_i,
  input  logic        deliver_i,
  input  logic [7:0]  sc_mask_i,
  input  logic        io_en_i,
  output logic [15:0] out_id_o,
  output logic [15:0] out_nr_o,
  output logic [31:0] out_parm_o,
  output logic [31:0] out_word_o,
  output logic        out_valid_o,
  output logic        err_o,
  output logic        pending_o
);
  localparam int unsigned NUM_SC = 8;
  localparam int unsigned SC_W   = $clog2(NUM_SC);

  irq_ent_t          push_ent;
  logic [SC_W-1:0]   push_sc;
  logic [ENT_W-1:0]  dout [NUM_SC];
  logic [NUM_SC-1:0] empty, full, nonempty, sel, pop_v;
  logic              hit, take, push_full;
  logic [ENT_W-1:0]  sel_ent;
  irq_ent_t          out_q;

  assign push_ent = '{id: push_id_i, nr: push_nr_i, parm: push_parm_i, word: push_word_i};
  assign push_sc  = push_word_i[SC_POS +: SC_W];

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    io_irq_lifo #(.DEPTH(DEPTH), .W(ENT_W)) u_lifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_i && (push_sc == SC_W'(g))),
      .pop_i   (pop_v[g]),
      .din_i   (push_ent),
      .dout_o  (dout[g]),
      .empty_o (empty[g]),
      .full_o  (full[g])
    );
  end

  assign nonempty = ~empty;

  io_irq_pick #(.N(NUM_SC)) u_pick (
    .req_i (nonempty),
    .en_i  (sc_mask_i),
    .sel_o (sel),
    .hit_o (hit)
  );

  assign take      = deliver_i && io_en_i && hit;
  assign pop_v     = (deliver_i && io_en_i) ? sel : '0;
  assign push_full = push_i && full[push_sc];

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NUM_SC; i++) begin
      if (sel[i]) sel_ent = sel_ent | dout[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      err_o       <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_o <= take;
      err_o       <= (deliver_i && !io_en_i) || push_full;
      if (take) out_q <= sel_ent;
    end
  end

  assign out_id_o   = out_q.id;
  assign out_nr_o   = out_q.nr;
  assign out_parm_o = out_q.parm;
  assign out_word_o = out_q.word;
  assign pending_o  = |nonempty;

  // R3
  one_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_v));
  // R2
  sel_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_v & ~(nonempty & sc_mask_i)) == '0);
  // R6
  disabled_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && !io_en_i) |=> (err_o && !out_valid_o));
  // R11
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(deliver_i && io_en_i));
  // R5
  pend_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && io_en_i && !pending_o) |=> !out_valid_o);
endmodule

// File: tb/sim_io_irq_sel.sv
`timescale 1ns/1ps
module sim_io_irq_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [15:0] push_id_i = '0;
  logic [15:0] push_nr_i = '0;
  logic [31:0] push_parm_i = '0;
  logic [31:0] push_word_i = '0;
  logic        deliver_i = 1'b0;
  logic [7:0]  sc_mask_i = '0;
  logic        io_en_i = 1'b0;
  logic [15:0] out_id_o, out_nr_o;
  logic [31:0] out_parm_o, out_word_o;
  logic        out_valid_o, err_o, pending_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 0;

  always #2.5 clk_i = ~clk_i;

  io_irq_sel u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        push;
    logic [2:0]  sc;
    logic [15:0] id;
    logic        del;
    logic [7:0]  mask;
    logic        en;
    logic        ev;
    logic [15:0] eid;
    logic        eerr;
    logic        epend;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd11, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0}, // R11 nothing queued
    '{4'd8,  1'b1, 3'd3, 16'h0301, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1}, // R8 route sc3
    '{4'd1,  1'b1, 3'd3, 16'h0302, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd8,  1'b1, 3'd5, 16'h0501, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd8,  1'b1, 3'd1, 16'h0101, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd2,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0101, 1'b0, 1'b1}, // R2 lowest first
    '{4'd1,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0302, 1'b0, 1'b1}, // R1 newest first
    '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hF7, 1'b1, 1'b1, 16'h0501, 1'b0, 1'b1}, // R4 sc3 skipped
    '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hF7, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1}, // R4 masked keeps pending
    '{4'd6,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1}, // R6 disabled
    '{4'd5,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0301, 1'b0, 1'b0}, // R5 drained, R6 no pop
    '{4'd11, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{4'd7,  1'b1, 3'd7, 16'h0701, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd7,  1'b1, 3'd7, 16'h0702, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd7,  1'b1, 3'd7, 16'h0703, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd7,  1'b1, 3'd7, 16'h0704, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd7,  1'b1, 3'd7, 16'h0705, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1}, // R7 full push
    '{4'd7,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0704, 1'b0, 1'b1}, // R7 top unchanged
    '{4'd3,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0703, 1'b0, 1'b1}, // R3 one per request
    '{4'd3,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0702, 1'b0, 1'b1},
    '{4'd7,  1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0701, 1'b0, 1'b0}, // R7 exactly DEPTH held
    '{4'd10, 1'b1, 3'd2, 16'h0201, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd10, 1'b1, 3'd2, 16'h0202, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0201, 1'b0, 1'b1}, // R10 old top out
    '{4'd10, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h0202, 1'b0, 1'b0}, // R10 new kept
    '{4'd2,  1'b1, 3'd6, 16'h0601, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd2,  1'b1, 3'd0, 16'h0001, 1'b0, 8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{4'd2,  1'b0, 3'd0, 16'h0000, 1'b1, 8'h40, 1'b1, 1'b1, 16'h0601, 1'b0, 1'b1}, // R2 sc0 masked
    '{4'd2,  1'b0, 3'd0, 16'h0000, 1'b1, 8'h01, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [2:0] sc, input logic [15:0] id);
    return (32'(sc) << 24) | 32'(id);
  endfunction

  task automatic drive_push(input bit p, input logic [2:0] sc, input logic [15:0] id);
    push_i      = p;
    push_id_i   = id;
    push_nr_i   = ~id;
    push_parm_i = {id, ~id};
    push_word_i = word_of(sc, id);
  endtask

  initial begin
    // R9 reset state while held
    #1;
    chk(out_valid_o == 1'b0, 9, "valid in reset", 32'(out_valid_o), 0);
    chk(err_o == 1'b0,       9, "err in reset",   32'(err_o), 0);
    chk(pending_o == 1'b0,   9, "pend in reset",  32'(pending_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pending_o == 1'b0, 9, "pend after reset", 32'(pending_o), 0);

    for (int k = 0; k < NV; k++) begin
      drive_push(VECS[k].push, VECS[k].sc, VECS[k].id);
      deliver_i = VECS[k].del;
      sc_mask_i = VECS[k].mask;
      io_en_i   = VECS[k].en;
      @(negedge clk_i);
      chk(out_valid_o == VECS[k].ev, VECS[k].req, $sformatf("vec %0d valid", k),
          32'(out_valid_o), 32'(VECS[k].ev));
      chk(err_o == VECS[k].eerr, VECS[k].req, $sformatf("vec %0d err", k),
          32'(err_o), 32'(VECS[k].eerr));
      chk(pending_o == VECS[k].epend, VECS[k].req, $sformatf("vec %0d pend", k),
          32'(pending_o), 32'(VECS[k].epend));
      if (VECS[k].ev) begin
        chk(out_id_o == VECS[k].eid, VECS[k].req, $sformatf("vec %0d id", k),
            32'(out_id_o), 32'(VECS[k].eid));
        // R8 full entry intact
        chk(out_nr_o == ~VECS[k].eid, 8, $sformatf("vec %0d nr", k),
            32'(out_nr_o), 32'(~VECS[k].eid));
        chk(out_parm_o == {VECS[k].eid, ~VECS[k].eid}, 8, $sformatf("vec %0d parm", k),
            out_parm_o, {VECS[k].eid, ~VECS[k].eid});
        chk(out_word_o == word_of(3'(VECS[k].eid >> 8), VECS[k].eid), 8,
            $sformatf("vec %0d word", k), out_word_o, word_of(3'(VECS[k].eid >> 8), VECS[k].eid));
      end
    end
    drive_push(1'b0, 3'd0, 16'h0);
    deliver_i = 1'b0;

    // R11 valid lasts one cycle
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, 11, "valid pulse width", 32'(out_valid_o), 0);

    // R9 reset in mid-run empties stacks
    drive_push(1'b1, 3'd4, 16'h0401);
    @(negedge clk_i);
    drive_push(1'b0, 3'd0, 16'h0);
    chk(pending_o == 1'b1, 9, "pend before reset", 32'(pending_o), 1);
    rst_ni = 1'b0;
    #1;
    chk(pending_o == 1'b0, 9, "pend in mid reset", 32'(pending_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    deliver_i = 1'b1;
    sc_mask_i = 8'hFF;
    io_en_i   = 1'b1;
    @(negedge clk_i);
    deliver_i = 1'b0;
    chk(out_valid_o == 1'b0, 9, "nothing after reset", 32'(out_valid_o), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule